// File: doc/BRIEF.md
# Long-Word Packer with Byte-Order Modes

This block sits on the write side of a 36-bit FIFO and turns a narrower write bus into full long words. A producer writes 36-bit long words, 18-bit words or 9-bit bytes. The partial pieces are collected in holding registers until a long word is complete. The complete long word is then rearranged by one of four byte-order modes and offered to the FIFO. The FIFO captures it on the same clock edge that delivers the final piece.

The bus size and endian selects are registered on every clock edge. A write uses the values that were registered at the edge before it.

- In big-endian mode, pieces arrive on the upper lanes of the bus. They fill the long word from the most significant byte downward.
- In little-endian mode, pieces arrive on the lower lanes. They fill the long word from byte 0 upward.

If a write arrives with a bus size different from the previous write, the partial word is discarded and assembly starts over. The byte-order mode is taken from the first piece of each long word.

Top module: `long_word_packer`

## Requirements
- R1: Size codes: 00 and 11 both mean long word, 01 means 18-bit word, 10 means 9-bit byte. Codes 00 and 11 count as the same size. In long-word mode, every write raises `push` in the same cycle, with the whole `wr_data` (after the byte-order mode) on `push_data`.
- R2: Word mode needs two writes per long word, and `push` rises only on the second.
  - Big-endian: pieces are taken from `wr_data[35:18]`. The first piece lands in bits 35:18 of the long word and the second in bits 17:0.
  - Little-endian: pieces are taken from `wr_data[17:0]`. The first piece lands in bits 17:0 and the second in bits 35:18.
- R3: Byte mode needs four writes per long word, and `push` rises only on the fourth. Byte k of the long word occupies bits 9k+8:9k.
  - Big-endian: pieces are taken from `wr_data[35:27]` and fill bytes 3, 2, 1, 0 in that order.
  - Little-endian: pieces are taken from `wr_data[8:0]` and fill bytes 0, 1, 2, 3 in that order.
- R4: A write whose registered size differs from that of the previous write restarts assembly. The partial data is dropped, and that write counts as the first piece of a new long word.
- R5: Byte-order modes act on the assembled long word. Each mode moves whole 9-bit bytes and keeps the bit order inside each byte. Writing the assembled bytes as {b3,b2,b1,b0}, the output is:
  - mode 00: {b3,b2,b1,b0}
  - mode 01: {b0,b1,b2,b3}
  - mode 10: {b1,b0,b3,b2}
  - mode 11: {b2,b3,b0,b1}
- R6: The byte-order mode is sampled on the write that starts a long word. It applies to that whole long word, whatever `swap_sel` shows on later pieces.
- R7: `size_sel` and `big_end` are registered on each rising edge. A write uses the values registered at the preceding edge, so a size change presented together with a write does not affect that write.
- R8: After reset, assembly is empty and no `push` occurs while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one piece |
| wr_data | input | 36 | Write data bus |
| size_sel | input | 2 | Bus size select (registered) |
| big_end | input | 1 | Endian select, 1 = big-endian (registered) |
| swap_sel | input | 2 | Byte-order mode, sampled on the first piece |
| push | output | 1 | FIFO write strobe, valid in the cycle of the last piece |
| push_data | output | 36 | Assembled and reordered long word |

## Verification
The bench sweeps every size code, both endian settings and all four byte-order modes. On each piece it drives a deliberately wrong pattern on the unused lanes, so that a design taking pieces from the wrong lanes, or placing them in the wrong byte order, shows corrupted `push_data`. Byte-order modes are changed on the later pieces of each word. A design that samples the mode on every piece would then push data in the wrong order.

Two sequences test restart behaviour:
- Two bytes followed by a switch to word mode. A design that keeps the partial count would push on the wrong write or mix stale bytes into the word.
- A size change presented in the same cycle as a write. A design without the one-cycle registration of the size select would finish or restart the word one write too early.

// File: rtl/pkr_pkg.sv
// Package: shared types and helpers for the long-word packer.
// Assumes a long word of exactly four lanes.
package pkr_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_LONG     = 2'b00,
        SZ_WORD     = 2'b01,
        SZ_BYTE     = 2'b10,
        SZ_LONG_ALT = 2'b11
    } size_e;

    // Fold the two long-word codes into one.
    function automatic size_e norm_size(input logic [1:0] code);
        return (code == SZ_LONG_ALT) ? SZ_LONG : size_e'(code);
    endfunction

    // Lanes carried by one piece.
    function automatic int lanes_per_piece(input size_e sz);
        case (sz)
            SZ_WORD: return 2;
            SZ_BYTE: return 1;
            default: return LANES;
        endcase
    endfunction

    // Slot index of the final piece of a long word.
    function automatic logic [1:0] final_slot(input size_e sz);
        case (sz)
            SZ_WORD: return 2'd1;
            SZ_BYTE: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pkr_ctrl.sv
// Module: pkr_ctrl
// Registers the size and endian selects, tracks which piece of the current
// long word is being written, and holds the byte-order mode chosen on the
// first piece. Assumes size_sel / big_end are stable around the clock edge.
module pkr_ctrl
    import pkr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] size_sel,
    input  logic       big_end,
    input  logic [1:0] swap_sel,
    output size_e      size_now,
    output logic       be_now,
    output logic [1:0] slot,
    output logic       first,
    output logic       last,
    output logic [1:0] swap_now
);

    size_e      size_q;
    size_e      prev_size;
    logic       be_q;
    logic [1:0] cnt;
    logic [1:0] swap_q;

    // Capture the selects every edge; they apply from the next edge on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_LONG;
            be_q   <= 1'b0;
        end else begin
            size_q <= norm_size(size_sel);
            be_q   <= big_end;
        end
    end

    // Work out the slot of this write, restarting on a size change.
    always_comb begin
        slot     = (size_q != prev_size) ? 2'd0 : cnt;
        first    = (slot == 2'd0);
        last     = (slot == final_slot(size_q));
        swap_now = first ? swap_sel : swap_q;
    end

    // Advance the piece counter and latch the mode on a first piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 2'd0;
            prev_size <= SZ_LONG;
            swap_q    <= 2'd0;
        end else if (wr_en) begin
            prev_size <= size_q;
            cnt       <= last ? 2'd0 : slot + 2'd1;
            if (first) swap_q <= swap_sel;
        end
    end

    assign size_now = size_q;
    assign be_now   = be_q;

    a_r7_size_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> size_q == norm_size($past(size_sel)));

    a_r4_restart_on_size: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size_q != prev_size && size_q != SZ_LONG) |=> cnt == 2'd1);

    a_r2_word_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_size == SZ_WORD) |-> cnt <= 2'd1);

    a_r1_long_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_size == SZ_LONG) |-> cnt == 2'd0);

    a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !first) |=> $stable(swap_q));

endmodule

// File: rtl/pkr_gather.sv
// Module: pkr_gather
// Places the incoming piece into its lanes of the long word and keeps the
// lanes already written in holding registers. The combined word is valid in
// the same cycle as the write. Assumes slot is within range for the size.
module pkr_gather
    import pkr_pkg::*;
#(
    parameter  int BYTE_W = 9,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  size_e             size_now,
    input  logic              be_now,
    input  logic [1:0]        slot,
    output logic [WORD_W-1:0] word_out
);

    logic [BYTE_W-1:0] in_b [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [BYTE_W-1:0] lane_v;
        logic [BYTE_W-1:0] hold_v;

        assign in_b[j] = wr_data[j*BYTE_W +: BYTE_W];

        // Pick this lane from the bus if the piece covers it, else keep it.
        always_comb begin
            int n;
            int base;
            int src;
            n = lanes_per_piece(size_now);
            if (be_now) begin
                base = LANES - n * (int'(slot) + 1);
                src  = j + n * int'(slot);
            end else begin
                base = n * int'(slot);
                src  = j - n * int'(slot);
            end
            if (j >= base && j < base + n) lane_v = in_b[src[1:0]];
            else                           lane_v = hold_v;
        end

        // Remember every lane written so far.
        always_ff @(posedge clk) begin
            if (!rst_n)     hold_v <= '0;
            else if (wr_en) hold_v <= lane_v;
        end

        assign word_out[j*BYTE_W +: BYTE_W] = lane_v;
    end

endmodule

// File: rtl/pkr_swap.sv
// Module: pkr_swap
// Reorders whole lanes of a long word by one of four modes. Bit order
// inside a lane is kept. Purely combinational.
module pkr_swap
    import pkr_pkg::*;
#(
    parameter  int BYTE_W = 9,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);

    logic [1:0] mask;

    // Map the mode to the lane-index mask: none, full reverse, halves, pairs.
    always_comb begin
        case (mode)
            2'b01:   mask = 2'b11;
            2'b10:   mask = 2'b10;
            2'b11:   mask = 2'b01;
            default: mask = 2'b00;
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic [1:0] src;
        assign src = 2'(j) ^ mask;
        assign word_out[j*BYTE_W +: BYTE_W] = word_in[int'(src)*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/long_word_packer.sv
// Module: long_word_packer (top)
// Gathers 36/18/9-bit writes into long words, reorders the finished long
// word and raises push in the cycle of the final piece, so the FIFO captures
// it on that same edge. Assumes the FIFO accepts push whenever it is raised.
module long_word_packer
    import pkr_pkg::*;
#(
    parameter  int BYTE_W = 9,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        size_sel,
    input  logic              big_end,
    input  logic [1:0]        swap_sel,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);

    size_e             size_now;
    logic              be_now;
    logic [1:0]        slot;
    logic              first;
    logic              last;
    logic [1:0]        swap_now;
    logic [WORD_W-1:0] gathered;

    pkr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .size_sel (size_sel),
        .big_end  (big_end),
        .swap_sel (swap_sel),
        .size_now (size_now),
        .be_now   (be_now),
        .slot     (slot),
        .first    (first),
        .last     (last),
        .swap_now (swap_now)
    );

    pkr_gather #(.BYTE_W(BYTE_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .size_now (size_now),
        .be_now   (be_now),
        .slot     (slot),
        .word_out (gathered)
    );

    pkr_swap #(.BYTE_W(BYTE_W)) u_swap (
        .mode     (swap_now),
        .word_in  (gathered),
        .word_out (push_data)
    );

    // Push when the piece that completes the long word is written.
    assign push = wr_en & last;

    a_r1_long_every_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size_now == SZ_LONG) |-> push);

    a_r5_bits_preserved: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $countones(push_data) == $countones(gathered));

    a_r8_push_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !push);

endmodule

// File: tb/test_long_word_packer.sv
module test_long_word_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [1:0]  size_sel = 2'b00;
    logic        big_end = 1'b0;
    logic [1:0]  swap_sel = 2'b00;
    logic        push;
    logic [35:0] push_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    long_word_packer i_long_word_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .size_sel  (size_sel),
        .big_end   (big_end),
        .swap_sel  (swap_sel),
        .push      (push),
        .push_data (push_data)
    );

    function automatic logic [35:0] exp_order(input logic [35:0] w, input logic [1:0] m);
        logic [8:0] b3, b2, b1, b0;
        b3 = w[35:27]; b2 = w[26:18]; b1 = w[17:9]; b0 = w[8:0];
        case (m)
            2'b01:   return {b0, b1, b2, b3};
            2'b10:   return {b1, b0, b3, b2};
            2'b11:   return {b2, b3, b0, b1};
            default: return {b3, b2, b1, b0};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sz, input logic be);
        @(negedge clk);
        wr_en = 1'b0; size_sel = sz; big_end = be;
        #2;
        check(push == 1'b0, "R8 idle no push", 36'(push), 36'h0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [35:0] d, input logic [1:0] sw, input bit exp_push,
                      input logic [35:0] exp_d, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; swap_sel = sw;
        #2;
        check(push == exp_push, {req, " push"}, 36'(push), 36'(exp_push));
        if (exp_push) check(push_data == exp_d, {req, " data"}, push_data, exp_d);
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    function automatic logic [35:0] piece(input logic [35:0] w, input logic [1:0] sz,
                                          input logic be, input int k);
        logic [35:0] g;
        logic [17:0] h;
        logic [8:0]  b;
        g = ~w ^ 36'h5A5A5A5A5;
        if (sz == 2'b01) begin
            if (be) begin h = (k == 0) ? w[35:18] : w[17:0]; return {h, g[17:0]}; end
            else begin    h = (k == 0) ? w[17:0] : w[35:18]; return {g[35:18], h}; end
        end else if (sz == 2'b10) begin
            if (be) begin b = w[(3-k)*9 +: 9]; return {b, g[26:0]}; end
            else begin    b = w[k*9 +: 9];     return {g[35:9], b}; end
        end
        return w;
    endfunction

    task automatic send_word(input logic [35:0] w, input logic [1:0] sz, input logic be,
                             input logic [1:0] m_first, input logic [1:0] m_rest, input string req);
        int n;
        n = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
        for (int k = 0; k < n; k++) begin
            wr(piece(w, sz, be, k), (k == 0) ? m_first : m_rest, (k == n-1),
               exp_order(w, m_first), req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(push == 1'b0, "R8 reset no push", 36'(push), 36'h0);

        // Sweep: all size codes, both endians, all modes (R1 R2 R3 R5 R6)
        for (int sz = 0; sz < 4; sz++) begin
            for (int be = 0; be < 2; be++) begin
                cfg(2'(sz), 1'(be));
                for (int m = 0; m < 4; m++) begin
                    w = 36'h123456789 + 36'(sz) * 36'h011111111 + 36'(be) * 36'h7
                        + 36'(m) * 36'h300000101;
                    send_word(w, 2'(sz), 1'(be), 2'(m), 2'(m + 1),
                              (sz == 1) ? "R2/R5/R6" : (sz == 2) ? "R3/R5/R6" : "R1/R5");
                end
            end
        end

        // R1: back-to-back long writes each push
        cfg(2'b00, 1'b0);
        for (int i = 0; i < 3; i++)
            send_word(36'hABCDE0123 ^ 36'(i * 77), 2'b00, 1'b0, 2'(i), 2'(i), "R1 burst");

        // R4: two bytes then switch to word; partial bytes dropped
        cfg(2'b10, 1'b1);
        wr(36'h111111111, 2'b00, 1'b0, 36'h0, "R4 byte0");
        wr(36'h222222222, 2'b00, 1'b0, 36'h0, "R4 byte1");
        cfg(2'b01, 1'b1);
        send_word(36'h9F0E1D2C3, 2'b01, 1'b1, 2'b00, 2'b00, "R4 restart word");

        // R7: size change with the final word piece still uses word size
        cfg(2'b01, 1'b0);
        w = 36'h0F1E2D3C4;
        wr(piece(w, 2'b01, 1'b0, 0), 2'b10, 1'b0, 36'h0, "R7 word0");
        @(negedge clk);
        wr_en = 1'b1; wr_data = piece(w, 2'b01, 1'b0, 1); swap_sel = 2'b00; size_sel = 2'b10;
        #2;
        check(push == 1'b1, "R7 old size push", 36'(push), 36'h1);
        check(push_data == exp_order(w, 2'b10), "R7 old size data", push_data, exp_order(w, 2'b10));
        @(posedge clk);
        #1 wr_en = 1'b0;
        send_word(36'h876543210, 2'b10, 1'b0, 2'b01, 2'b11, "R7/R4 new byte word");

        // R7: size change with a first piece; that piece stays a word piece
        cfg(2'b01, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 36'h3C3C3C3C3; size_sel = 2'b10;
        #2;
        check(push == 1'b0, "R7 first piece no push", 36'(push), 36'h0);
        @(posedge clk);
        #1 wr_en = 1'b0;
        send_word(36'h55AA33CC1, 2'b10, 1'b1, 2'b11, 2'b00, "R7/R4 bytes after change");

        // R8: reset in mid-assembly empties the word
        wr(36'h1, 2'b00, 1'b0, 36'h0, "R8 partial");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg(2'b10, 1'b1);
        send_word(36'h13579BDF0, 2'b10, 1'b1, 2'b10, 2'b01, "R8 after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule